// File: doc/BRIEF.md
# Double-Buffered Sample Memory Fetcher

This block carries captured samples out of a large external sample memory towards the host in fixed-size chunks. It has two on-chip buffer banks. While one bank is being filled from external memory, the other can be drained to the host. The host drives it with single command bytes. The upper nibble of each byte is the opcode, and for the buffer-related opcodes bit 4 names the bank. A separate byte port loads the starting memory row.

The fetch engine reads external memory through a request/valid port and keeps at most one request outstanding. The stream engine presents one byte per cycle on a valid/ready output. The host must place explicit wait commands between steps so that a bank is never drained before its fill has finished. The intended order is:

1. Fetch bank 0, then wait.
2. For every chunk: fetch the opposite bank (skipped on the last chunk), stream the current bank, then wait (skipped on the last chunk).

The chunk length must be a power of two.

Top module: `dbuf_sample_fetcher`

## Requirements
- R1: Each `row_wr` pulse shifts `row_byte` into the low byte of the row register, so two pulses load the row with the first byte as the high byte. Every memory request carries `mem_addr = {row, byte offset}`.
- R2: A fetch command (opcode nibble 0x6, or 0x7 for bank 1; `cmd_byte[4]` is the bank) copies CHUNK_BYTES bytes into that bank. It reads offsets 0 up to CHUNK_BYTES-1 in ascending order. Each `mem_req` is a single-cycle pulse, and the next one is issued only after `mem_rvalid` has returned the previous byte.
- R3: The row register increases by one when a fetch writes its final byte.
- R4: A wait command (nibble 0x5) keeps `cmd_ready` low while a fetch is in progress, and it is taken in the first cycle the fetch engine is idle.
- R5: A full stream command (nibble 0xA, or 0xB for bank 1) sends all CHUNK_BYTES bytes of the bank in offset order. It moves one byte per cycle while `out_ready` is high, and holds `out_valid` and `out_data` unchanged while `out_ready` is low.
- R6: A partial stream command (nibble 0x8, or 0x9 for bank 1) sends only the first PART_BYTES bytes of the bank and then drops `out_valid`.
- R7: A fetch into one bank and a stream from the other bank run at the same time. `fetch_busy` and `stream_busy` can both be high in the same cycle.
- R8: A fetch command that names the bank currently streaming is taken but not started. It sets `err`, issues no request and leaves the row unchanged. `err` stays high until reset.
- R9: `cmd_ready` is low for a fetch command while a fetch is in progress. It is also low for a stream command while a stream is in progress or while the named bank is being filled.
- R10: Command bytes with any other opcode nibble are taken at once and change no state.
- R11: After reset:
  - no request is issued and no output byte is valid;
  - both busy flags and `err` are low;
  - the row is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Opcode in [7:4], bank select in [4] |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| row_wr | input | 1 | Shift one byte into the row register |
| row_byte | input | 8 | Row byte, high byte written first |
| mem_req | output | 1 | Single-cycle read request to external memory |
| mem_addr | output | ROW_W+log2(CHUNK_BYTES) | Row and byte offset of the request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Returned byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte to host |
| out_ready | input | 1 | Host accepts the byte |
| fetch_busy | output | 1 | Bank fill in progress |
| stream_busy | output | 1 | Bank drain in progress |
| err | output | 1 | Sticky bank-conflict flag |

## Verification
Internal state shows up at the ports within a cycle or so:
- A wrong fetch counter or row shows up on `mem_addr` at the very next request.
- A lost bank-select bit only appears later, when that bank is streamed and the bytes do not match the rows that were fetched.
- A wrong stream length appears on `out_valid` right after the last expected byte.
- A broken command gate shows up as `cmd_ready` taking a command in a cycle where it should stall.

Because of this, the outputs are compared against a behavioural model on every clock, and the streamed bytes are also checked end to end against the memory contents.

// File: rtl/dsf_pkg.sv
// Shared types for the double-buffered sample fetcher.
// Assumes: exactly two buffer banks; the bank is chosen by command bit 4.
package dsf_pkg;

    localparam int NBANK = 2;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_WAIT,
        CK_FETCH,
        CK_PART,
        CK_FULL
    } cmd_kind_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_WAIT
    } fstate_e;

    // Map an opcode nibble to the command class handled by this block.
    function automatic cmd_kind_e classify(input logic [3:0] op);
        cmd_kind_e k;
        unique case (op)
            4'h5:        k = CK_WAIT;
            4'h6, 4'h7:  k = CK_FETCH;
            4'h8, 4'h9:  k = CK_PART;
            4'hA, 4'hB:  k = CK_FULL;
            default:     k = CK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dsf_cmd_ctrl.sv
// Command gate and row register.
// Decodes opcode nibbles and decides when each command may be taken.
// Starts the fetch and stream engines, and flags fetches that would
// overwrite the bank being streamed.
// Assumes: one command per cycle; engine busy flags are registered.
module dsf_cmd_ctrl
    import dsf_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    output logic             cmd_ready,
    input  logic             row_wr,
    input  logic [7:0]       row_byte,
    input  logic             fetch_busy,
    input  logic             fetch_bank,
    input  logic             fetch_done,
    input  logic             stream_busy,
    input  logic             stream_bank,
    output logic             fetch_start,
    output logic             stream_start,
    output logic             stream_full,
    output logic             start_bank,
    output logic [ROW_W-1:0] row_q,
    output logic             err
);

    cmd_kind_e kind;
    logic      accept;
    logic      clash;

    // Classify the present command and pick its bank.
    always_comb begin
        kind       = classify(cmd_op);
        start_bank = cmd_op[0];
    end

    // Readiness per command class.
    always_comb begin
        unique case (kind)
            CK_WAIT, CK_FETCH: cmd_ready = !fetch_busy;
            CK_PART, CK_FULL:  cmd_ready = !stream_busy &&
                                           !(fetch_busy && fetch_bank == start_bank);
            default:           cmd_ready = 1'b1;
        endcase
    end

    // Start pulses for the engines.
    always_comb begin
        accept       = cmd_valid && cmd_ready;
        clash        = stream_busy && (stream_bank == start_bank);
        fetch_start  = accept && (kind == CK_FETCH) && !clash;
        stream_start = accept && ((kind == CK_PART) || (kind == CK_FULL));
        stream_full  = (kind == CK_FULL);
    end

    // Sticky conflict flag for a refused fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (accept && (kind == CK_FETCH) && clash)
            err <= 1'b1;
    end

    // Row register: byte shift on write, step after each completed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (row_wr)
            row_q <= {row_q[ROW_W-9:0], row_byte};
        else if (fetch_done)
            row_q <= row_q + 1'b1;
    end

endmodule

// File: rtl/dsf_fetch_engine.sv
// Chunk fetch engine.
// Reads CHUNK_BYTES bytes of one row from external memory with a
// single outstanding request, and writes them into the chosen bank.
// Assumes: memory returns exactly one mem_rvalid pulse per request.
module dsf_fetch_engine
    import dsf_pkg::*;
#(
    parameter int CHUNK_BYTES = 1024,
    parameter int ROW_W       = 16,
    localparam int OFF_W      = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bank,
    input  logic [ROW_W-1:0] row,
    output logic             mem_req,
    output logic [ROW_W+OFF_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             bank,
    output logic             done,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(CHUNK_BYTES - 1);

    fstate_e          state;
    logic [OFF_W-1:0] cnt;

    // Request, wait for data, repeat until the chunk is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            cnt   <= '0;
            bank  <= 1'b0;
        end else begin
            unique case (state)
                F_IDLE: if (start) begin
                    state <= F_REQ;
                    cnt   <= '0;
                    bank  <= start_bank;
                end
                F_REQ:  state <= F_WAIT;
                F_WAIT: if (mem_rvalid) begin
                    if (cnt == LAST_OFF) begin
                        state <= F_IDLE;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= F_REQ;
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    // Memory port and bank write side.
    always_comb begin
        busy     = (state != F_IDLE);
        mem_req  = (state == F_REQ);
        mem_addr = {row, cnt};
        wr_en    = (state == F_WAIT) && mem_rvalid;
        wr_addr  = cnt;
        wr_data  = mem_rdata;
        done     = wr_en && (cnt == LAST_OFF);
    end

endmodule

// File: rtl/dsf_bank_store.sv
// Two on-chip buffer banks.
// One write port, shared by the fetch engine, and one asynchronous read
// port, used by the stream engine.
// Assumes: the command gate keeps the write and read from touching the
// same bank at the same time.
module dsf_bank_store
    import dsf_pkg::*;
#(
    parameter int CHUNK_BYTES = 1024,
    localparam int OFF_W      = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [OFF_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_bank,
    input  logic [OFF_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);

    logic [7:0] rd_word [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [7:0] mem [CHUNK_BYTES];

        // Store a fetched byte into this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(g)))
                mem[wr_addr] <= wr_data;
        end

        assign rd_word[g] = mem[rd_addr];
    end

    // Select the bank being drained.
    always_comb rd_data = rd_word[rd_bank];

endmodule

// File: rtl/dsf_stream_engine.sv
// Bank drain engine.
// Walks one bank from offset 0 for either the whole chunk or the short
// prefix, one byte per accepted handshake.
// Assumes: the start pulse only arrives while idle.
module dsf_stream_engine #(
    parameter int CHUNK_BYTES = 1024,
    parameter int PART_BYTES  = 4,
    localparam int OFF_W      = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bank,
    input  logic             full,
    input  logic             out_ready,
    output logic             busy,
    output logic             bank,
    output logic [OFF_W-1:0] rd_addr
);

    localparam logic [OFF_W-1:0] FULL_LAST = OFF_W'(CHUNK_BYTES - 1);
    localparam logic [OFF_W-1:0] PART_LAST = OFF_W'(PART_BYTES - 1);

    logic [OFF_W-1:0] idx;
    logic [OFF_W-1:0] last_idx;

    // Track position and end of the current drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            bank     <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            bank     <= start_bank;
            idx      <= '0;
            last_idx <= full ? FULL_LAST : PART_LAST;
        end else if (busy && out_ready) begin
            if (idx == last_idx)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    assign rd_addr = idx;

endmodule

// File: rtl/dbuf_sample_fetcher.sv
// Double-buffered sample memory fetcher, top level.
// Wires the command gate, the fetch engine, the two-bank store and the
// stream engine together. The low nibble of a command byte carries no
// operand for this block.
// Assumes: CHUNK_BYTES is a power of two, PART_BYTES <= CHUNK_BYTES,
// and ROW_W >= 8.
module dbuf_sample_fetcher #(
    parameter int CHUNK_BYTES = 1024,
    parameter int PART_BYTES  = 4,
    parameter int ROW_W       = 16,
    localparam int OFF_W      = $clog2(CHUNK_BYTES),
    localparam int ADDR_W     = ROW_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic              cmd_ready,
    input  logic              row_wr,
    input  logic [7:0]        row_byte,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              fetch_busy,
    output logic              stream_busy,
    output logic              err
);

    logic             fetch_start;
    logic             stream_start;
    logic             stream_full;
    logic             start_bank;
    logic [ROW_W-1:0] row_q;
    logic             fetch_bank;
    logic             fetch_done;
    logic             stream_bank;
    logic             wr_en;
    logic [OFF_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [OFF_W-1:0] rd_addr;
    wire              unused_operand = &{1'b0, cmd_byte[3:0]};

    dsf_cmd_ctrl #(.ROW_W(ROW_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_byte[7:4]),
        .cmd_ready    (cmd_ready),
        .row_wr       (row_wr),
        .row_byte     (row_byte),
        .fetch_busy   (fetch_busy),
        .fetch_bank   (fetch_bank),
        .fetch_done   (fetch_done),
        .stream_busy  (stream_busy),
        .stream_bank  (stream_bank),
        .fetch_start  (fetch_start),
        .stream_start (stream_start),
        .stream_full  (stream_full),
        .start_bank   (start_bank),
        .row_q        (row_q),
        .err          (err)
    );

    dsf_fetch_engine #(.CHUNK_BYTES(CHUNK_BYTES), .ROW_W(ROW_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .start_bank (start_bank),
        .row        (row_q),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (fetch_busy),
        .bank       (fetch_bank),
        .done       (fetch_done),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    dsf_bank_store #(.CHUNK_BYTES(CHUNK_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (fetch_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (stream_bank),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    dsf_stream_engine #(.CHUNK_BYTES(CHUNK_BYTES), .PART_BYTES(PART_BYTES)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (stream_start),
        .start_bank (start_bank),
        .full       (stream_full),
        .out_ready  (out_ready),
        .busy       (stream_busy),
        .bank       (stream_bank),
        .rd_addr    (rd_addr)
    );

    assign out_valid = stream_busy;

endmodule

// File: rtl/dsf_fetcher_chk.sv
// Protocol checker for dbuf_sample_fetcher, attached with bind.
// Observes ports plus the row register and the fetch completion pulse.
module dsf_fetcher_chk #(
    parameter int ROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_byte,
    input logic             cmd_ready,
    input logic             mem_req,
    input logic             fetch_busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             err,
    input logic             row_wr,
    input logic [ROW_W-1:0] row_q,
    input logic             fetch_done
);

    // R2: requests are single-cycle pulses, one outstanding at a time.
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R2: no request outside an active fetch.
    p_req_in_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fetch_busy);

    // R3: row steps by one after the final byte of a fetch.
    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && !row_wr) |=> (row_q == $past(row_q) + 1'b1));

    // R4: a wait command stalls while a fetch runs.
    p_wait_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:4] == 4'h5 && fetch_busy) |-> !cmd_ready);

    // R5: output byte held while the host is not ready.
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: conflict flag stays set until reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9: a second fetch stalls while one runs.
    p_fetch_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b011 && fetch_busy) |-> !cmd_ready);

endmodule

bind dbuf_sample_fetcher dsf_fetcher_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .cmd_ready  (cmd_ready),
    .mem_req    (mem_req),
    .fetch_busy (fetch_busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .err        (err),
    .row_wr     (row_wr),
    .row_q      (row_q),
    .fetch_done (fetch_done)
);

// File: tb/dbuf_sample_fetcher_tb.sv
// Bench: behavioural cycle model compared on every clock, plus directed
// end-to-end data checks. External memory is modelled by a responder.
module dbuf_sample_fetcher_tb;

    localparam int CHUNK  = 32;
    localparam int PART   = 4;
    localparam int ROW_W  = 16;
    localparam int OFF_W  = 5;
    localparam int ADDR_W = ROW_W + OFF_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_byte = 8'h00;
    logic              cmd_ready;
    logic              row_wr = 1'b0;
    logic [7:0]        row_byte = 8'h00;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [7:0]        mem_rdata = 8'h00;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              out_ready = 1'b1;
    logic              fetch_busy;
    logic              stream_busy;
    logic              err;

    dbuf_sample_fetcher #(.CHUNK_BYTES(CHUNK), .PART_BYTES(PART), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_ready(cmd_ready), .row_wr(row_wr), .row_byte(row_byte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .fetch_busy(fetch_busy), .stream_busy(stream_busy),
        .err(err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory contents as a function of the address.
    function automatic logic [7:0] mem_fn(input int a);
        int t;
        t = a * 37 + (a >>> 5) * 11 + 5;
        return t[7:0];
    endfunction

    function automatic int addr_of(input int row, input int off);
        return (row << OFF_W) | off;
    endfunction

    // External memory responder with adjustable latency.
    int lat = 2;
    int pend = 0;
    int paddr = 0;
    bit hit;
    logic [ADDR_W-1:0] hit_addr;
    always @(posedge clk) begin
        hit = mem_req;
        hit_addr = mem_addr;
        #2;
        mem_rvalid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_fn(paddr);
            end
        end
        if (hit) begin
            paddr = int'(hit_addr);
            pend  = lat;
        end
    end

    // Host ready pattern: 0 always, 1 alternating, 2 never.
    int ready_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        #2;
        cyc++;
        out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
    end

    // Behavioural reference model.
    bit         m_live = 1'b0;
    bit         m_fbusy, m_fbank, m_fphase, m_sbusy, m_sbank, m_err;
    int         m_fcnt, m_sidx, m_slen, m_row;
    logic [7:0] m_bank [2][CHUNK];

    function automatic bit model_ready();
        logic [3:0] op;
        op = cmd_byte[7:4];
        if (op == 4'h5 || op == 4'h6 || op == 4'h7) return !m_fbusy;
        if (op >= 4'h8 && op <= 4'hB) return !m_sbusy && !(m_fbusy && m_fbank == op[0]);
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = 1'b1;
            m_fbusy = 0; m_fbank = 0; m_fphase = 0; m_sbusy = 0; m_sbank = 0; m_err = 0;
            m_fcnt = 0; m_sidx = 0; m_slen = 0; m_row = 0;
        end else if (m_live) begin
            bit acc, clash, fin;
            logic [3:0] op;
            op    = cmd_byte[7:4];
            acc   = cmd_valid && model_ready();
            clash = m_sbusy && (m_sbank == op[0]);
            fin   = 1'b0;
            if (m_sbusy && out_ready) begin
                if (m_sidx == m_slen - 1) m_sbusy = 0;
                else m_sidx++;
            end
            if (m_fbusy) begin
                if (m_fphase == 0) m_fphase = 1;
                else if (mem_rvalid) begin
                    m_bank[m_fbank][m_fcnt] = mem_rdata;
                    if (m_fcnt == CHUNK - 1) begin m_fbusy = 0; fin = 1; end
                    else begin m_fcnt++; m_fphase = 0; end
                end
            end
            if (row_wr) m_row = ((m_row << 8) | row_byte) & 16'hFFFF;
            else if (fin) m_row = (m_row + 1) & 16'hFFFF;
            if (acc) begin
                if (op == 4'h6 || op == 4'h7) begin
                    if (clash) m_err = 1;
                    else begin m_fbusy = 1; m_fbank = op[0]; m_fcnt = 0; m_fphase = 0; end
                end else if (op >= 4'h8 && op <= 4'hB) begin
                    m_sbusy = 1; m_sbank = op[0]; m_sidx = 0;
                    m_slen = (op[1]) ? CHUNK : PART;
                end
            end
        end
    end

    // Per-cycle comparison and monitors, away from the active edge.
    logic [7:0] sq [$];
    bit seen_overlap = 1'b0;
    bit cap_arm = 1'b0;
    int cap_addr = -1;
    always @(negedge clk) begin
        if (m_live) begin
            chk(cmd_ready == model_ready(), "R9 cmd_ready", cmd_ready, model_ready());
            chk(mem_req == (m_fbusy && !m_fphase), "R2 mem_req", mem_req, m_fbusy && !m_fphase);
            if (mem_req)
                chk(int'(mem_addr) == addr_of(m_row, m_fcnt), "R1 mem_addr",
                    mem_addr, addr_of(m_row, m_fcnt));
            chk(out_valid == m_sbusy, "R5 out_valid", out_valid, m_sbusy);
            if (out_valid && m_sbusy)
                chk(out_data == m_bank[m_sbank][m_sidx], "R5 out_data",
                    out_data, m_bank[m_sbank][m_sidx]);
            chk(fetch_busy == m_fbusy, "R7 fetch_busy", fetch_busy, m_fbusy);
            chk(stream_busy == m_sbusy, "R7 stream_busy", stream_busy, m_sbusy);
            chk(err == m_err, "R8 err", err, m_err);
        end
        if (out_valid && out_ready) sq.push_back(out_data);
        if (fetch_busy && stream_busy) seen_overlap = 1'b1;
        if (cap_arm && mem_req) begin
            cap_addr = int'(mem_addr);
            cap_arm  = 1'b0;
        end
    end

    task automatic send_cmd(input logic [7:0] b, output int stalls);
        stalls = 0;
        @(posedge clk); #2;
        cmd_valid = 1'b1;
        cmd_byte  = b;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
            stalls++;
        end
        @(posedge clk); #2;
        cmd_valid = 1'b0;
        cmd_byte  = 8'h00;
    endtask

    task automatic write_row(input logic [7:0] hi, input logic [7:0] lo);
        @(posedge clk); #2; row_wr = 1'b1; row_byte = hi;
        @(posedge clk); #2; row_byte = lo;
        @(posedge clk); #2; row_wr = 1'b0;
    endtask

    task automatic wait_stream_idle();
        do @(negedge clk); while (stream_busy);
    endtask

    task automatic check_chunk(input int base, input int row, input int n, input string tag);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int off = 0; off < n; off++) begin
            logic [7:0] e;
            e = mem_fn(addr_of(row, off));
            if (base + off >= sq.size() || sq[base + off] !== e) begin
                if (bad == 0) begin
                    first_act = (base + off < sq.size()) ? int'(sq[base + off]) : -1;
                    first_exp = int'(e);
                end
                bad++;
            end
        end
        chk(bad == 0, tag, first_act, first_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WATCHDOG", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int st;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(!mem_req && !out_valid, "R11 idle outputs", {mem_req, out_valid}, 0);
        chk(!fetch_busy && !stream_busy && !err, "R11 flags", {fetch_busy, stream_busy, err}, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        write_row(8'h12, 8'h34);
        // R10: foreign opcodes are taken at once and change nothing
        send_cmd(8'h00, st); chk(st == 0, "R10 taken", st, 0);
        send_cmd(8'h15, st);
        send_cmd(8'h4F, st);
        send_cmd(8'hC3, st); chk(st == 0, "R10 taken", st, 0);
        @(negedge clk);
        chk(!fetch_busy && !stream_busy && !out_valid, "R10 no effect",
            {fetch_busy, stream_busy, out_valid}, 0);

        // Host sequence over three chunks.
        cap_arm = 1'b1;
        send_cmd(8'h60, st);
        send_cmd(8'h50, st);
        chk(st > 0, "R4 wait stalled", st, 1);
        @(negedge clk);
        chk(!fetch_busy, "R4 fetch idle after wait", fetch_busy, 0);
        chk(cap_addr == addr_of(16'h1234, 0), "R1 first address", cap_addr, addr_of(16'h1234, 0));
        sq.delete();
        for (int i = 0; i < 3; i++) begin
            bit last;
            last = (i == 2);
            if (!last) send_cmd((i % 2 == 0) ? 8'h70 : 8'h60, st);
            send_cmd((i % 2 == 0) ? 8'hA0 : 8'hB0, st);
            if (!last) send_cmd(8'h50, st);
        end
        wait_stream_idle();
        chk(sq.size() == 3 * CHUNK, "R5 byte count", sq.size(), 3 * CHUNK);
        check_chunk(0, 16'h1234, CHUNK, "R2 chunk0 data");
        check_chunk(CHUNK, 16'h1235, CHUNK, "R3 chunk1 data");
        check_chunk(2 * CHUNK, 16'h1236, CHUNK, "R3 chunk2 data");
        chk(seen_overlap, "R7 overlap seen", seen_overlap, 1);

        // R6: partial read of bank 1 with host back-pressure.
        sq.delete();
        ready_mode = 1;
        send_cmd(8'h90, st);
        wait_stream_idle();
        ready_mode = 0;
        repeat (3) @(negedge clk);
        chk(sq.size() == PART, "R6 partial count", sq.size(), PART);
        check_chunk(0, 16'h1235, PART, "R6 partial data");

        // R9: stalls for a busy fetch and for a stream of a filling bank.
        lat = 1;
        send_cmd(8'h70, st);
        send_cmd(8'h60, st);
        chk(st > 0, "R9 fetch stalled", st, 1);
        sq.delete();
        send_cmd(8'hA0, st);
        chk(st > 0, "R9 stream of filling bank stalled", st, 1);
        wait_stream_idle();
        check_chunk(0, 16'h1238, CHUNK, "R9 data after stall");

        // R8: fetch into the bank that is streaming.
        sq.delete();
        ready_mode = 2;
        send_cmd(8'hB0, st);
        send_cmd(8'h70, st);
        begin
            int reqs = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (mem_req || fetch_busy) reqs++;
            end
            chk(reqs == 0, "R8 no fetch started", reqs, 0);
        end
        chk(err, "R8 err set", err, 1);
        ready_mode = 0;
        wait_stream_idle();
        check_chunk(0, 16'h1237, CHUNK, "R8 streamed bank intact");
        cap_arm = 1'b1;
        send_cmd(8'h60, st);
        send_cmd(8'h50, st);
        chk(cap_addr == addr_of(16'h1239, 0), "R8 row unchanged", cap_addr, addr_of(16'h1239, 0));
        chk(err, "R8 err sticky", err, 1);

        // R1: new row value, first byte high.
        write_row(8'hAB, 8'hCD);
        cap_arm = 1'b1;
        send_cmd(8'h70, st);
        send_cmd(8'h50, st);
        chk(cap_addr == addr_of(16'hABCD, 0), "R1 reloaded row", cap_addr, addr_of(16'hABCD, 0));
        sq.delete();
        send_cmd(8'hB0, st);
        wait_stream_idle();
        check_chunk(0, 16'hABCD, CHUNK, "R1 data at new row");

        // R11: reset clears flags and row.
        @(posedge clk); #2; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!err && !fetch_busy && !stream_busy, "R11 after reset", {err, fetch_busy, stream_busy}, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        cap_arm = 1'b1;
        send_cmd(8'h60, st);
        send_cmd(8'h50, st);
        chk(cap_addr == 0, "R11 row zero", cap_addr, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule